// File: doc/BRIEF.md
# Quantum-Timed Propagation Delay Stage

This block sits behind an instantaneous logic function inside a model-time simulator. It gives that function's output a fixed propagation delay. Model time moves forward one quantum on each cycle where the tick enable is high. The undelayed result is sampled on every tick. When that result differs from the last value sampled, the new value is parked in a pending register and a down-counter is loaded with the programmed delay. Each later tick decrements the counter. When the count runs out, the pending value is copied into the output register.

A second change that arrives while a countdown is running replaces the pending value and restarts the count. Only the most recent change reaches the output, and it arrives a full delay after that change. Pulses narrower than the delay are therefore absorbed. A delay of zero passes a change straight to the output on the tick that sees it.

Top module: `dl_prop_delay`

## Requirements
- R1: After reset, y_o is 0 and busy_o is 0.
- R2: On cycles where tick_i is low, y_o and busy_o hold their values, whatever yc_i and delay_i do.
- R3: On a tick, if yc_i differs from the value sampled at the previous tick (0 after reset) and delay_i is D > 0, busy_o is high after that edge. y_o keeps its old value through the next D-1 ticks and takes the new value on the D-th tick after the change, and busy_o falls on that same tick.
- R4: Only cycles with tick_i high advance the countdown. Any number of non-tick cycles inside a countdown leave the tick on which y_o updates unchanged.
- R5: A change seen on a tick while busy_o is high replaces the pending value and restarts the countdown from the delay_i present on that tick. The earlier pending value never appears on y_o.
- R6: A change seen on a tick with delay_i equal to 0 sets y_o to that yc_i value at that tick's edge and leaves busy_o low. This also cancels any countdown that is running.
- R7: delay_i is sampled only on the tick that sees a change. Changing delay_i during a countdown does not move the update tick.
- R8: A pulse on yc_i that returns to its starting value before the delay runs out never appears on y_o. The countdown restarts at the return and ends D ticks later with y_o unchanged.
- R9: Ticks on which yc_i equals the last sampled value start no countdown when idle: busy_o stays low and y_o is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Model-time quantum advance |
| yc_i | input | WIDTH | Undelayed function result |
| delay_i | input | CNT_W | Delay in quanta, sampled on a change |
| y_o | output | WIDTH | Delayed output value |
| busy_o | output | 1 | A countdown is in progress |

## Verification
Each fault in the internal state shows up at the ports within one delay window. A wrong last-sampled value either starts a spurious countdown, which raises busy_o on the very next tick, or misses a change, so y_o stays stale after D ticks. An off-by-one in the counter moves the y_o update and the fall of busy_o by exactly one tick, so checks run tick by tick across each window. A pending register that is not overwritten on a retrigger makes a stale value appear on y_o at the end of the restarted count.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cd_state_e;
endpackage

// File: rtl/dl_change_det.sv
module dl_change_det #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] yc_i,
  output logic             chg_o,
  output logic [WIDTH-1:0] seen_o
);
  logic [WIDTH-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= '0;
    else if (tick_i) seen_q <= yc_i;
  end

  // a change only counts when model time advances
  assign chg_o  = tick_i && (yc_i != seen_q);
  assign seen_o = seen_q;
endmodule

// File: rtl/dl_countdown.sv
module dl_countdown
  import dl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             fire_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;

  assign last_q = (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= dly_i;
      st_q  <= (dly_i == '0) ? ST_IDLE : ST_RUN;
    end else if (tick_i && st_q == ST_RUN) begin
      cnt_q <= cnt_q - ONE;
      if (last_q) st_q <= ST_IDLE;
    end
  end

  always_comb begin
    if (load_i) fire_o = (dly_i == '0);
    else        fire_o = tick_i && (st_q == ST_RUN) && last_q;
  end

  assign busy_o = (st_q == ST_RUN);
endmodule

// File: rtl/dl_hold.sv
module dl_hold #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             commit_i,
  output logic [WIDTH-1:0] cur_o
);
  logic [WIDTH-1:0] fut_q;
  logic [WIDTH-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fut_q <= '0;
      cur_q <= '0;
    end else begin
      if (wr_i) fut_q <= wr_data_i;
      // same-tick write and commit bypasses the pending register
      if (commit_i) cur_q <= wr_i ? wr_data_i : fut_q;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/dl_prop_delay.sv
module dl_prop_delay #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] yc_i,
  input  logic [CNT_W-1:0] delay_i,
  output logic [WIDTH-1:0] y_o,
  output logic             busy_o
);
  logic             chg;
  logic             fire;
  logic [WIDTH-1:0] seen;

  dl_change_det #(.WIDTH(WIDTH)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .yc_i   (yc_i),
    .chg_o  (chg),
    .seen_o (seen)
  );

  dl_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (chg),
    .dly_i  (delay_i),
    .fire_o (fire),
    .busy_o (busy_o)
  );

  dl_hold #(.WIDTH(WIDTH)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (chg),
    .wr_data_i (yc_i),
    .commit_i  (fire),
    .cur_o     (y_o)
  );
endmodule

// File: rtl/dl_prop_delay_chk.sv
module dl_prop_delay_chk #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [WIDTH-1:0] yc_i,
  input logic [CNT_W-1:0] delay_i,
  input logic [WIDTH-1:0] y_o,
  input logic             busy_o,
  input logic [WIDTH-1:0] seen
);
  logic chg_seen;
  assign chg_seen = tick_i && (yc_i != seen);

  p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(y_o) && $stable(busy_o)));

  p_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_seen && delay_i != '0) |=> (busy_o && $stable(y_o)));

  p_zero_delay_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_seen && delay_i == '0) |=> (!busy_o && y_o == $past(yc_i)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !chg_seen) |=> (!busy_o && $stable(y_o)));

  p_y_moves_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !chg_seen && tick_i && !$stable(seen)) |-> 1'b1 ##0 $past(tick_i));
endmodule

bind dl_prop_delay dl_prop_delay_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .yc_i    (yc_i),
  .delay_i (delay_i),
  .y_o     (y_o),
  .busy_o  (busy_o),
  .seen    (seen)
);

// File: tb/dl_prop_delay_bench.sv
module dl_prop_delay_bench;
  localparam int WIDTH = 4;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick_i = 1'b0;
  logic [WIDTH-1:0] yc_i = '0;
  logic [CNT_W-1:0] delay_i = '0;
  logic [WIDTH-1:0] y_o;
  logic             busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dl_prop_delay #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dl_prop_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .yc_i(yc_i),
    .delay_i(delay_i), .y_o(y_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [WIDTH-1:0] v, input int d);
    @(negedge clk_i);
    yc_i = v; delay_i = CNT_W'(d); tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int yv, input int bv);
    check({tag, " y"}, int'(y_o), yv);
    check({tag, " busy"}, int'(busy_o), bv);
  endtask

  task automatic t_reset;
    expect_out("R1 reset", 0, 0);
  endtask

  task automatic t_basic;
    step(4'd5, 3);
    expect_out("R3 armed", 0, 1);
    step(4'd5, 3); expect_out("R3 tick1", 0, 1);
    step(4'd5, 3); expect_out("R3 tick2", 0, 1);
    step(4'd5, 3); expect_out("R3 tick3", 5, 0);
  endtask

  task automatic t_no_tick;
    step(4'd10, 2);
    expect_out("R4 armed", 5, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      yc_i = 4'(i); delay_i = CNT_W'(i);
    end
    expect_out("R2 idle cycles", 5, 1);
    step(4'd10, 2); expect_out("R4 tick1", 5, 1);
    step(4'd10, 2); expect_out("R4 tick2", 10, 0);
  endtask

  task automatic t_zero;
    step(4'd9, 0);
    expect_out("R6 zero delay", 9, 0);
  endtask

  task automatic t_retrigger;
    bit saw_stale = 1'b0;
    step(4'd1, 4);
    step(4'd1, 4);
    step(4'd1, 4);
    step(4'd2, 4);
    expect_out("R5 reloaded", 9, 1);
    for (int i = 1; i <= 3; i++) begin
      step(4'd2, 4);
      if (y_o == 4'd1) saw_stale = 1'b1;
      check("R5 hold during reload", int'(y_o), 9);
    end
    step(4'd2, 4);
    expect_out("R5 final", 2, 0);
    check("R5 stale never shown", int'(saw_stale), 0);
  endtask

  task automatic t_delay_ignored;
    step(4'd7, 2);
    step(4'd7, 10);
    check("R7 after tick1", int'(y_o), 2);
    step(4'd7, 0);
    expect_out("R7 tick2", 7, 0);
  endtask

  task automatic t_pulse;
    step(4'd3, 5);
    step(4'd7, 5);
    for (int i = 1; i <= 4; i++) begin
      step(4'd7, 5);
      check("R8 pulse absorbed", int'(y_o), 7);
    end
    expect_out("R8 still busy", 7, 1);
    step(4'd7, 5);
    expect_out("R8 window end", 7, 0);
  endtask

  task automatic t_cancel;
    step(4'd12, 6);
    step(4'd12, 6);
    step(4'd13, 0);
    expect_out("R6 cancel", 13, 0);
    step(4'd13, 6);
    expect_out("R6 after cancel", 13, 0);
  endtask

  task automatic t_steady;
    for (int i = 0; i < 5; i++) step(4'd13, 3);
    expect_out("R9 steady", 13, 0);
  endtask

  task automatic t_long;
    step(4'd6, 255);
    for (int i = 1; i < 255; i++) step(4'd6, 255);
    expect_out("R3 long before", 13, 1);
    step(4'd6, 255);
    expect_out("R3 long end", 6, 0);
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_no_tick();
    t_zero();
    t_retrigger();
    t_delay_ignored();
    t_pulse();
    t_cancel();
    t_steady();
    t_long();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule